// File: doc/BRIEF.md
# Successive-Approximation Tuning Word Controller

This block produces the tuning word that sets the output frequency of a phase-accumulator synthesizer inside a closed frequency-measurement loop. A frequency comparator outside the block reports, through a direction bit and a valid strobe, whether the synthesized frequency should rise or fall. The controller turns that stream of decisions into a new tuning word. When the loop has settled, the tuning word is the digital estimate of the unknown input frequency.

A start pulse opens a measurement with a binary search. The word is placed at the middle of the configured range, and the first correction is a quarter of that range. Every accepted decision moves the word by the current step and then halves the step. When the step has fallen to one, the controller becomes a plain up/down counter that moves the word by one per strobe. From then on it follows a drifting input for as long as needed, with no restart between readings. The configured maximum stands for the highest usable synthesizer frequency, about a quarter of the synthesizer clock. The word never leaves the range from zero to that maximum.

Top module: `sa_tune_ctrl`

## Requirements
- R1: After reset the tuning word is 0 and `searching_o` is 0. Direction strobes have no effect on the word until the first start pulse.
- R2: In the cycle after a start pulse, the tuning word equals `max_word_i` shifted right by one (floor of half). `searching_o` is 1 whenever `max_word_i` shifted right by two is greater than 1.
- R3: The first search step is `max_word_i` shifted right by two. Each accepted search decision with `dir_up_i`=1 adds the current step, and with `dir_up_i`=0 subtracts it. The step is then shifted right by one.
- R4: The update whose halved step is 1 or less moves the word by the old step and, in the same cycle, drops `searching_o` to 0. After that, every strobe moves the word by exactly one in the commanded direction, so a steady comparator holds the word within one of the target.
- R5: A search decision is accepted only when `dir_valid_i` is 1 and the dwell count is at least `min_dwell_i`. The dwell count is 0 in the first cycle after a start or an accepted search update, and it rises by one per clock after that. Strobes arriving earlier are dropped and are not queued.
- R6: The word saturates. An upward move that would pass `max_word_i` gives `max_word_i`, and a downward move larger than the word gives 0. It never wraps around.
- R7: A start pulse while tracking abandons tracking and restarts the search from the mid-range value.
- R8: Once tracking, the controller stays in tracking for any number of strobes until the next start pulse.
- R9: If `max_word_i` shifted right by two is 1 or less, a start pulse loads the mid-range value and enters tracking directly, with `searching_o` at 0.
- R10: A start pulse takes priority over a direction strobe in the same cycle. The word loads the mid-range value and the strobe is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle pulse that begins a new search |
| dir_valid_i | input | 1 | Comparator decision strobe |
| dir_up_i | input | 1 | 1 = raise the word, 0 = lower it |
| max_word_i | input | W | Highest allowed tuning word |
| min_dwell_i | input | DW | Minimum dwell count before a search decision is accepted |
| tune_word_o | output | W | Tuning word to the synthesizer |
| searching_o | output | 1 | 1 during the binary search, 0 while tracking or idle |

## Verification
A wrong step register or phase bit shows up at the port in the cycle right after the next accepted decision. The word then moves by the wrong amount, or `searching_o` falls too early or too late. A dwell counter that is off by one accepts or drops the strobe at the boundary, so the word changes one cycle too early or fails to change at all. A saturation fault only appears once the word reaches either end of the range, so the word is driven hard into both limits and compared against a reference model on every clock.

// File: rtl/sa_tune_pkg.sv
package sa_tune_pkg;
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SEARCH = 2'd1,
        PH_TRACK  = 2'd2
    } phase_e;
endpackage

// File: rtl/sa_dwell_timer.sv
module sa_dwell_timer #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic [DW-1:0] limit_i,
    output logic          ready_o
);
    localparam logic [DW-1:0] CNT_TOP = {DW{1'b1}};

    logic [DW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear_i)
            cnt_d = '0;
        else if (cnt_q != CNT_TOP)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign ready_o = (cnt_q >= limit_i);

    // R5: the cycle after a clear is ready only for a zero dwell limit
    assert_clear_restarts_dwell_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_i && $stable(limit_i)) |=> (ready_o == (limit_i == '0)));
endmodule

// File: rtl/sa_sat_step.sv
module sa_sat_step #(
    parameter int W = 16
) (
    input  logic [W-1:0] word_i,
    input  logic [W-1:0] delta_i,
    input  logic         up_i,
    input  logic [W-1:0] max_i,
    output logic [W-1:0] res_o
);
    logic [W:0] sum;

    always_comb begin
        sum = {1'b0, word_i} + {1'b0, delta_i};
        if (up_i)
            res_o = (sum > {1'b0, max_i}) ? max_i : sum[W-1:0];
        else
            res_o = (delta_i > word_i) ? '0 : (word_i - delta_i);
    end

    // R6: a word inside the range stays inside the range
    always_comb begin
        if (word_i <= max_i)
            assert_sat_in_range_R6: assert (res_o <= max_i);
    end
endmodule

// File: rtl/sa_tune_ctrl.sv
module sa_tune_ctrl
    import sa_tune_pkg::*;
#(
    parameter int W  = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          dir_valid_i,
    input  logic          dir_up_i,
    input  logic [W-1:0]  max_word_i,
    input  logic [DW-1:0] min_dwell_i,
    output logic [W-1:0]  tune_word_o,
    output logic          searching_o
);
    typedef struct packed {
        phase_e       phase;
        logic [W-1:0] word;
        logic [W-1:0] step;
    } ctl_t;

    ctl_t         st_d, st_q;
    logic         dwell_ok;
    logic         take_search;
    logic [W-1:0] delta;
    logic [W-1:0] moved;
    logic [W-1:0] half_range;
    logic [W-1:0] quarter_range;
    logic [W-1:0] next_step;

    assign half_range    = max_word_i >> 1;
    assign quarter_range = max_word_i >> 2;
    assign next_step     = st_q.step >> 1;
    assign delta         = (st_q.phase == PH_SEARCH) ? st_q.step : W'(1);

    sa_sat_step #(.W(W)) u_sat (
        .word_i  (st_q.word),
        .delta_i (delta),
        .up_i    (dir_up_i),
        .max_i   (max_word_i),
        .res_o   (moved)
    );

    sa_dwell_timer #(.DW(DW)) u_dwell (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (start_i | take_search),
        .limit_i (min_dwell_i),
        .ready_o (dwell_ok)
    );

    always_comb begin
        st_d        = st_q;
        take_search = 1'b0;
        if (start_i) begin
            st_d.word  = half_range;
            st_d.step  = quarter_range;
            st_d.phase = (quarter_range > W'(1)) ? PH_SEARCH : PH_TRACK;
        end else begin
            case (st_q.phase)
                PH_SEARCH: begin
                    if (dir_valid_i && dwell_ok) begin
                        take_search = 1'b1;
                        st_d.word   = moved;
                        st_d.step   = next_step;
                        if (next_step <= W'(1))
                            st_d.phase = PH_TRACK;
                    end
                end
                PH_TRACK: begin
                    if (dir_valid_i)
                        st_d.word = moved;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.phase <= PH_IDLE;
            st_q.word  <= '0;
            st_q.step  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tune_word_o = st_q.word;
    assign searching_o = (st_q.phase == PH_SEARCH);

    // R1: idle ignores strobes
    assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_IDLE && !start_i) |=> (tune_word_o == '0));

    // R2: start loads mid-range
    assert_mid_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (tune_word_o == ($past(max_word_i) >> 1)));

    // R4: tracking moves by at most one
    assert_track_unit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_TRACK && dir_valid_i && !start_i) |=>
            (tune_word_o == $past(tune_word_o) ||
             tune_word_o == W'($past(tune_word_o) + 1'b1) ||
             tune_word_o == W'($past(tune_word_o) - 1'b1)));

    // R5: without a strobe or start the word holds
    assert_hold_without_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && !dir_valid_i) |=> $stable(tune_word_o));

    // R8: search ends only into tracking, tracking never resumes search alone
    assert_track_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_TRACK && !start_i) |=> !searching_o);
endmodule

// File: tb/sa_tune_ctrl_test.sv
module sa_tune_ctrl_test;
    localparam int W  = 16;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          dir_valid_i = 1'b0;
    logic          dir_up_i = 1'b0;
    logic [W-1:0]  max_word_i = 16'd1000;
    logic [DW-1:0] min_dwell_i = '0;
    logic [W-1:0]  tune_word_o;
    logic          searching_o;

    int errors = 0;
    int checks = 0;

    // reference model state
    int m_word = 0, m_step = 0, m_phase = 0, m_cnt = 0;

    always #5 clk = ~clk;

    sa_tune_ctrl #(.W(W), .DW(DW)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .dir_valid_i(dir_valid_i), .dir_up_i(dir_up_i),
        .max_word_i(max_word_i), .min_dwell_i(min_dwell_i),
        .tune_word_o(tune_word_o), .searching_o(searching_o)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int move(input int w, input int d, input bit up, input int mx);
        if (up) return (w + d > mx) ? mx : w + d;
        return (d > w) ? 0 : w - d;
    endfunction

    // behavioural model: phase 0 idle, 1 search, 2 track
    always @(posedge clk) begin
        if (!rst_n) begin
            m_word = 0; m_step = 0; m_phase = 0; m_cnt = 0;
        end else if (start_i) begin
            m_word  = int'(max_word_i) / 2;
            m_step  = int'(max_word_i) / 4;
            m_phase = (m_step > 1) ? 1 : 2;
            m_cnt   = 0;
        end else if (m_phase == 1) begin
            if (dir_valid_i && m_cnt >= int'(min_dwell_i)) begin
                m_word = move(m_word, m_step, dir_up_i, int'(max_word_i));
                m_step = m_step / 2;
                if (m_step <= 1) m_phase = 2;
                m_cnt = 0;
            end else begin
                m_cnt++;
            end
        end else if (m_phase == 2) begin
            if (dir_valid_i) m_word = move(m_word, 1, dir_up_i, int'(max_word_i));
        end
    end

    // compare against the model on every clock (R3 R5 R6)
    always @(negedge clk) begin
        if (rst_n) begin
            check(int'(tune_word_o) == m_word, "R3/R5/R6 model word", int'(tune_word_o), m_word);
            check(searching_o == (m_phase == 1), "R4 model phase flag", int'(searching_o), int'(m_phase == 1));
        end
    end

    task automatic drive(input bit s, input bit v, input bit d);
        start_i = s; dir_valid_i = v; dir_up_i = d;
        @(negedge clk);
        start_i = 1'b0; dir_valid_i = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(tune_word_o == 0, "R1 reset word", int'(tune_word_o), 0);
        check(searching_o == 0, "R1 reset flag", int'(searching_o), 0);
        repeat (3) drive(0, 1, 1);
        check(tune_word_o == 0, "R1 strobes ignored before start", int'(tune_word_o), 0);

        // search with max 1000, no dwell
        drive(1, 0, 0);
        check(tune_word_o == 500, "R2 mid-range load", int'(tune_word_o), 500);
        check(searching_o == 1, "R2 search flag", int'(searching_o), 1);
        drive(0, 1, 1);
        check(tune_word_o == 750, "R3 first step up", int'(tune_word_o), 750);
        drive(0, 1, 0);
        check(tune_word_o == 625, "R3 second step down", int'(tune_word_o), 625);
        repeat (4) drive(0, 1, 1);
        check(tune_word_o == 740 && searching_o == 1, "R3 steps 62 31 15 7", int'(tune_word_o), 740);
        drive(0, 1, 1);
        check(tune_word_o == 743, "R4 last step of 3", int'(tune_word_o), 743);
        check(searching_o == 0, "R4 flag drops at step 1", int'(searching_o), 0);
        drive(0, 1, 1);
        check(tune_word_o == 744, "R4 unit track step", int'(tune_word_o), 744);
        repeat (300) drive(0, 1, 1);
        check(tune_word_o == 1000, "R6 saturate at max", int'(tune_word_o), 1000);
        check(searching_o == 0, "R8 still tracking", int'(searching_o), 0);
        repeat (1100) drive(0, 1, 0);
        check(tune_word_o == 0, "R6 saturate at zero", int'(tune_word_o), 0);

        // restart from tracking, then start beating a strobe
        drive(1, 0, 0);
        check(tune_word_o == 500 && searching_o == 1, "R7 restart from tracking", int'(tune_word_o), 500);
        drive(0, 1, 0);
        drive(1, 1, 1);
        check(tune_word_o == 500, "R10 start wins over strobe", int'(tune_word_o), 500);

        // dwell of 3
        min_dwell_i = 8'd3;
        drive(1, 0, 0);
        repeat (3) drive(0, 1, 1);
        check(tune_word_o == 500, "R5 early strobes dropped", int'(tune_word_o), 500);
        drive(0, 1, 1);
        check(tune_word_o == 750, "R5 strobe at dwell accepted", int'(tune_word_o), 750);
        drive(0, 1, 1);
        check(tune_word_o == 750, "R5 dwell restarts after update", int'(tune_word_o), 750);

        // tiny range enters tracking directly
        min_dwell_i = 8'd0;
        max_word_i = 16'd7;
        drive(1, 0, 0);
        check(tune_word_o == 3 && searching_o == 0, "R9 direct tracking", int'(tune_word_o), 3);
        drive(0, 1, 1);
        check(tune_word_o == 4, "R9 unit step after direct entry", int'(tune_word_o), 4);

        // closed-loop convergence toward a target
        max_word_i = 16'd60000;
        min_dwell_i = 8'd2;
        drive(1, 0, 0);
        for (int i = 0; i < 400; i++) drive(0, 1, tune_word_o < 16'd12345);
        check(int'(tune_word_o) >= 12344 && int'(tune_word_o) <= 12346,
              "R4 converges near target", int'(tune_word_o), 12345);
        check(searching_o == 0, "R8 loop keeps tracking", int'(searching_o), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule